// File: doc/BRIEF.md
# Weighted round-robin submission queue arbiter

This block decides which of `NQ` submission queues the controller takes its next command from. Each queue presents a ready flag, meaning it holds at least one command, and a 2-bit priority class. A 32-bit configuration word supplies three class weights and a burst limit. The arbiter issues a one-cycle, one-hot grant for a single command fetch. It then waits for the fetch engine to pulse `fetch_done` before it arbitrates again.

Two modes exist, selected by `wrr_mode`. Plain round robin (mode 0) gives every ready queue equal standing and serves one command per turn in circular order. Weighted mode (mode 1) serves urgent queues first, with strict priority, in circular order among themselves. The high, medium and low classes then share per-class credits. A queue chosen in weighted mode keeps the grant for a run of up to min(weight+1, burst) commands. Credits and the configuration word are reloaded only at a round boundary.

The controller sequence uses four states:
- **PICK** evaluates the request masks. It goes to GRANT when a queue is chosen, to RELOAD when weighted work is waiting but no weighted class has credit left, and otherwise stays in PICK.
- **RELOAD** lasts one cycle. It refills the credits, latches the configuration and returns to PICK.
- **GRANT** drives the grant for one cycle and always moves on to WAIT.
- **WAIT** holds until `fetch_done` is seen and then returns to PICK.

Top module: `wrr_queue_arbiter`

## Requirements
- R1: While `rst_n` is low, and after release until a queue is ready, `grant` is all zeros. Reset leaves every search pointer at queue `NQ-1`, so the first search starts at queue 0.
- R2: Each grant lasts exactly one cycle. It is one-hot and names a queue that was ready in the cycle before it.
- R3: After a grant, no further grant is issued until `fetch_done` is high in a cycle when the arbiter is waiting. `fetch_done` in any other cycle has no effect. The next grant comes two cycles after the accepted pulse at the earliest.
- R4: With `wrr_mode`=0, queues are served one command per turn, in circular index order starting after the last queue served in this mode. The priority class is ignored.
- R5: The class field of queue i is `q_prio[2i+1:2i]`, with 0 = urgent, 1 = high, 2 = medium and 3 = low.
- R6: With `wrr_mode`=1, any ready urgent queue is served before every weighted queue. Urgent queues are taken one command each, in circular order among themselves.
- R7: `arb_cfg[2:0]` is the burst code, `arb_cfg[7:3]` is ignored, and bits [15:8], [23:16] and [31:24] are the low, medium and high weights.
- R8: Burst code c in 0..6 limits a run to 2^c commands. Code 7 removes the limit, so only the weight applies.
- R9: A newly chosen weighted queue runs for min(weight+1, burst) commands. A run also ends when its class credit reaches zero.
- R10: A weight w allows w+1 commands per class per round. A class with no credit left is skipped until the next reload.
- R11: Credits are reloaded only when weighted work is waiting and no ready weighted queue has credit left. A reload costs one extra cycle, ends any unfinished run, and the new round starts searching after the last weighted queue served.
- R12: Empty queues are skipped without spending credit. A queue that empties during its run gives up the rest of that run.
- R13: A configuration word written mid-round takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrr_mode | input | 1 | 0 = plain round robin, 1 = weighted with urgent class |
| q_ready | input | NQ | Per-queue "holds a command" flag |
| q_prio | input | 2*NQ | Per-queue 2-bit class, queue i at bits [2i+1:2i] |
| arb_cfg | input | 32 | Burst code and the three class weights |
| fetch_done | input | 1 | Pulse that ends the current command fetch |
| grant | output | NQ | One-hot, one-cycle fetch grant |

## Verification
The decision is made from inputs sampled at the clock edge that leaves PICK, and the grant is visible for the following cycle. When no reload is needed, a grant is therefore due one cycle after the deciding edge. When a reload is needed, it is due two cycles later. A `fetch_done` accepted at an edge allows the next grant two edges later. The bench keeps a behavioural model that advances on the same edges from the same inputs. It compares `grant` against that model at every falling edge, half a cycle after the outputs settle. Inputs change just after the falling edge, so no decision straddles a stimulus change.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

    typedef enum logic [1:0] {
        ST_PICK   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_GRANT  = 2'd2,
        ST_WAIT   = 2'd3
    } arb_state_e;

    typedef enum logic [2:0] {
        PK_NONE   = 3'd0,
        PK_PLAIN  = 3'd1,
        PK_URGENT = 3'd2,
        PK_CONT   = 3'd3,
        PK_NEW    = 3'd4,
        PK_RELOAD = 3'd5
    } pick_kind_e;

    localparam logic [1:0] CLS_URGENT = 2'd0;
    localparam logic [1:0] CLS_HIGH   = 2'd1;
    localparam logic [1:0] CLS_MEDIUM = 2'd2;
    localparam logic [1:0] CLS_LOW    = 2'd3;

    localparam int NUM_WCLS       = 3;
    localparam int CFG_BURST_LSB  = 0;
    localparam int CFG_BURST_W    = 3;
    localparam int CFG_WEIGHT_LSB = 8;
    localparam int CFG_WEIGHT_W   = 8;
    localparam int CNT_W          = CFG_WEIGHT_W + 1;

    localparam logic [CFG_BURST_W-1:0] BURST_UNLIMITED = '1;

    // Burst code to command count; the unlimited code yields a count no weight can exceed.
    function automatic logic [CNT_W-1:0] burst_to_count(input logic [CFG_BURST_W-1:0] code);
        if (code == BURST_UNLIMITED) begin
            return CNT_W'(1 << CFG_WEIGHT_W);
        end
        return CNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int NQ = 8,
    parameter int IW = 3
) (
    input  logic [NQ-1:0] req_i,
    input  logic [IW-1:0] last_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Circular search for the first request after last_i, wrapping around to last_i itself.
    always_comb begin
        found_o = 1'b0;
        idx_o   = last_i;
        for (int k = 1; k <= NQ; k++) begin
            int j;
            j = int'(last_i) + k;
            if (j >= NQ) begin
                j = j - NQ;
            end
            if (!found_o && req_i[j]) begin
                found_o = 1'b1;
                idx_o   = IW'(j);
            end
        end
    end

endmodule

// File: rtl/wrr_credit_bank.sv
module wrr_credit_bank
    import wrr_arb_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reload_i,
    input  logic [CFG_BURST_W-1:0]                burst_i,
    input  logic [NUM_WCLS*CFG_WEIGHT_W-1:0]      weights_i,
    input  logic                                  dec_i,
    input  logic [1:0]                            dec_cls_i,
    output logic [NUM_WCLS-1:0]                   has_credit_o,
    output logic [NUM_WCLS-1:0][CNT_W-1:0]        run_len_o
);

    logic [CFG_BURST_W-1:0] burst_code_q;
    logic [CNT_W-1:0]       burst_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_code_q <= '0;
        end else if (reload_i) begin
            burst_code_q <= burst_i;
        end
    end

    assign burst_cnt = burst_to_count(burst_code_q);

    // Index 0 = high, 1 = medium, 2 = low (class code minus one).
    generate
        for (genvar c = 0; c < NUM_WCLS; c++) begin : g_cls
            logic [CFG_WEIGHT_W-1:0] w_in;
            logic [CFG_WEIGHT_W-1:0] w_q;
            logic [CNT_W-1:0]        credit_q;
            logic [CNT_W-1:0]        per_round;

            // Weights arrive low, medium, high from LSB upward; class index runs the other way.
            assign w_in = weights_i[(NUM_WCLS-1-c)*CFG_WEIGHT_W +: CFG_WEIGHT_W];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    w_q      <= '0;
                    credit_q <= '0;
                end else if (reload_i) begin
                    w_q      <= w_in;
                    credit_q <= {1'b0, w_in} + CNT_W'(1);
                end else if (dec_i && dec_cls_i == 2'(c)) begin
                    credit_q <= credit_q - CNT_W'(1);
                end
            end

            assign per_round       = {1'b0, w_q} + CNT_W'(1);
            assign run_len_o[c]    = (per_round < burst_cnt) ? per_round : burst_cnt;
            assign has_credit_o[c] = (credit_q != '0);

            // R10: a class is never charged once its credit is spent
            p_credit_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (dec_i && dec_cls_i == 2'(c)) |-> (credit_q != '0));
        end
    endgenerate

endmodule

// File: rtl/wrr_queue_arbiter.sv
module wrr_queue_arbiter
    import wrr_arb_pkg::*;
#(
    parameter int NQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrr_mode,
    input  logic [NQ-1:0]   q_ready,
    input  logic [2*NQ-1:0] q_prio,
    input  logic [31:0]     arb_cfg,
    input  logic            fetch_done,
    output logic [NQ-1:0]   grant
);

    localparam int            IW       = (NQ > 1) ? $clog2(NQ) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NQ - 1);

    arb_state_e state_q, state_d;
    pick_kind_e kind;

    logic [IW-1:0]    sel_q, rr_ptr_q, urg_ptr_q, wt_ptr_q;
    logic [CNT_W-1:0] run_left_q;
    logic [IW-1:0]    pick_idx;
    logic [1:0]       pick_cls;
    logic [CNT_W-1:0] new_len;

    logic [NQ-1:0] urg_req, wt_req, wt_elig;
    logic [NUM_WCLS-1:0]            has_credit;
    logic [NUM_WCLS-1:0][CNT_W-1:0] run_len;

    logic pl_found, ur_found, wt_found;
    logic [IW-1:0] pl_idx, ur_idx, wt_idx;
    logic cont_ok, dec, reload;
    logic [1:0] dec_cls;
    logic cfg_unused;

    assign cfg_unused = ^arb_cfg[CFG_WEIGHT_LSB-1:CFG_BURST_W];

    // Per-queue request masks
    generate
        for (genvar i = 0; i < NQ; i++) begin : g_q
            logic [1:0] qcls;
            logic       ok;
            assign qcls       = q_prio[2*i +: 2];
            assign urg_req[i] = q_ready[i] && (qcls == CLS_URGENT);
            assign wt_req[i]  = q_ready[i] && (qcls != CLS_URGENT);
            always_comb begin
                unique case (qcls)
                    CLS_HIGH:   ok = has_credit[0];
                    CLS_MEDIUM: ok = has_credit[1];
                    CLS_LOW:    ok = has_credit[2];
                    default:    ok = 1'b0;
                endcase
            end
            assign wt_elig[i] = wt_req[i] && ok;
        end
    endgenerate

    rr_pick #(.NQ(NQ), .IW(IW)) u_pick_plain (
        .req_i(q_ready), .last_i(rr_ptr_q), .found_o(pl_found), .idx_o(pl_idx));
    rr_pick #(.NQ(NQ), .IW(IW)) u_pick_urgent (
        .req_i(urg_req), .last_i(urg_ptr_q), .found_o(ur_found), .idx_o(ur_idx));
    rr_pick #(.NQ(NQ), .IW(IW)) u_pick_weighted (
        .req_i(wt_elig), .last_i(wt_ptr_q), .found_o(wt_found), .idx_o(wt_idx));

    wrr_credit_bank u_credit (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_i     (reload),
        .burst_i      (arb_cfg[CFG_BURST_LSB +: CFG_BURST_W]),
        .weights_i    (arb_cfg[CFG_WEIGHT_LSB +: NUM_WCLS*CFG_WEIGHT_W]),
        .dec_i        (dec),
        .dec_cls_i    (dec_cls),
        .has_credit_o (has_credit),
        .run_len_o    (run_len)
    );

    assign cont_ok = (run_left_q != '0) && wt_elig[wt_ptr_q];

    // Selection priority for the PICK state
    always_comb begin
        kind     = PK_NONE;
        pick_idx = sel_q;
        if (!wrr_mode) begin
            if (pl_found) begin
                kind     = PK_PLAIN;
                pick_idx = pl_idx;
            end
        end else if (ur_found) begin
            kind     = PK_URGENT;
            pick_idx = ur_idx;
        end else if (cont_ok) begin
            kind     = PK_CONT;
            pick_idx = wt_ptr_q;
        end else if (wt_found) begin
            kind     = PK_NEW;
            pick_idx = wt_idx;
        end else if (|wt_req) begin
            kind     = PK_RELOAD;
        end
    end

    assign pick_cls = q_prio[2*int'(pick_idx) +: 2];
    assign dec_cls  = pick_cls - 2'd1;
    assign dec      = (state_q == ST_PICK) && ((kind == PK_CONT) || (kind == PK_NEW));
    assign reload   = (state_q == ST_RELOAD);

    always_comb begin
        unique case (pick_cls)
            CLS_HIGH:   new_len = run_len[0];
            CLS_MEDIUM: new_len = run_len[1];
            CLS_LOW:    new_len = run_len[2];
            default:    new_len = CNT_W'(1);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PICK: begin
                if (kind == PK_RELOAD) begin
                    state_d = ST_RELOAD;
                end else if (kind != PK_NONE) begin
                    state_d = ST_GRANT;
                end
            end
            ST_RELOAD: state_d = ST_PICK;
            ST_GRANT:  state_d = ST_WAIT;
            ST_WAIT:   state_d = fetch_done ? ST_PICK : ST_WAIT;
            default:   state_d = ST_PICK;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PICK;
        end else begin
            state_q <= state_d;
        end
    end

    // Selection, pointers and run length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= '0;
            rr_ptr_q   <= LAST_IDX;
            urg_ptr_q  <= LAST_IDX;
            wt_ptr_q   <= LAST_IDX;
            run_left_q <= '0;
        end else if (state_q == ST_PICK) begin
            unique case (kind)
                PK_PLAIN: begin
                    sel_q    <= pick_idx;
                    rr_ptr_q <= pick_idx;
                end
                PK_URGENT: begin
                    sel_q     <= pick_idx;
                    urg_ptr_q <= pick_idx;
                end
                PK_CONT: begin
                    sel_q      <= pick_idx;
                    run_left_q <= run_left_q - CNT_W'(1);
                end
                PK_NEW: begin
                    sel_q      <= pick_idx;
                    wt_ptr_q   <= pick_idx;
                    run_left_q <= new_len - CNT_W'(1);
                end
                default: begin
                end
            endcase
        end else if (state_q == ST_RELOAD) begin
            run_left_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        grant = '0;
        if (state_q == ST_GRANT) begin
            grant[sel_q] = 1'b1;
        end
    end

    // R2: at most one queue granted
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: a grant lasts one cycle
    p_grant_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (grant == '0));

    // R2: only a queue that was ready at the decision is granted
    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (|(grant & $past(q_ready))));

    // R6: a non-urgent grant in weighted mode means no urgent queue was waiting
    p_urgent_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && $past(wrr_mode) && !(|(grant & $past(urg_req))))
            |-> !(|$past(urg_req)));

endmodule

// File: tb/wrr_queue_arbiter_test.sv
module wrr_queue_arbiter_test;

    localparam int NQ = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wrr_mode = 1'b0;
    logic [NQ-1:0]   q_ready;
    logic [2*NQ-1:0] q_prio = '0;
    logic [31:0]     arb_cfg = '0;
    logic            fetch_done = 1'b0;
    logic [NQ-1:0]   grant;

    int depth [NQ];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int resp_delay = 1;
    bit stray_en = 1'b0;
    bit pending = 1'b0;
    int dly = 0;
    int gq[$];
    string cur_req = "R1";

    // model state
    int m_phase, m_sel, m_rr, m_ug, m_wt, m_run, m_burst;
    int m_cred [3];
    int m_w [3];

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NQ; i++) q_ready[i] = (depth[i] > 0);
    end

    wrr_queue_arbiter #(.NQ(NQ)) uut (
        .clk(clk), .rst_n(rst_n), .wrr_mode(wrr_mode), .q_ready(q_ready),
        .q_prio(q_prio), .arb_cfg(arb_cfg), .fetch_done(fetch_done), .grant(grant));

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic int find_next(input logic [NQ-1:0] req, input int last);
        for (int k = 1; k <= NQ; k++) begin
            int j;
            j = (last + k) % NQ;
            if (req[j]) return j;
        end
        return -1;
    endfunction

    function automatic int cls_of(input int i);
        return int'(q_prio[2*i +: 2]);
    endfunction

    function automatic int sum_depth();
        int s = 0;
        for (int i = 0; i < NQ; i++) s += depth[i];
        return s;
    endfunction

    // Behavioural reference model: one step per rising edge
    always @(posedge clk or negedge rst_n) begin : model
        int j, c, len;
        bit anyw;
        logic [NQ-1:0] ur, el;
        if (!rst_n) begin
            m_phase = 0; m_sel = 0; m_rr = NQ-1; m_ug = NQ-1; m_wt = NQ-1;
            m_run = 0; m_burst = 1;
            for (int k = 0; k < 3; k++) begin m_cred[k] = 0; m_w[k] = 0; end
        end else begin
            case (m_phase)
                0: begin
                    if (!wrr_mode) begin
                        j = find_next(q_ready, m_rr);
                        if (j >= 0) begin m_sel = j; m_rr = j; m_phase = 2; end
                    end else begin
                        anyw = 0;
                        for (int i = 0; i < NQ; i++) begin
                            ur[i] = q_ready[i] && cls_of(i) == 0;
                            el[i] = q_ready[i] && cls_of(i) != 0 && m_cred[(cls_of(i)+2)%3] > 0;
                            if (q_ready[i] && cls_of(i) != 0) anyw = 1;
                        end
                        j = find_next(ur, m_ug);
                        if (j >= 0) begin
                            m_sel = j; m_ug = j; m_phase = 2;
                        end else if (m_run > 0 && el[m_wt]) begin
                            m_sel = m_wt; m_run--; m_cred[cls_of(m_wt)-1]--; m_phase = 2;
                        end else begin
                            j = find_next(el, m_wt);
                            if (j >= 0) begin
                                c = cls_of(j) - 1;
                                len = m_w[c] + 1;
                                if (m_burst < len) len = m_burst;
                                m_sel = j; m_wt = j; m_run = len - 1; m_cred[c]--; m_phase = 2;
                            end else if (anyw) begin
                                m_phase = 1;
                            end
                        end
                    end
                end
                1: begin
                    m_w[0] = int'(arb_cfg[31:24]);
                    m_w[1] = int'(arb_cfg[23:16]);
                    m_w[2] = int'(arb_cfg[15:8]);
                    for (int k = 0; k < 3; k++) m_cred[k] = m_w[k] + 1;
                    m_burst = (arb_cfg[2:0] == 3'd7) ? 256 : (1 << arb_cfg[2:0]);
                    m_run = 0;
                    m_phase = 0;
                end
                2: m_phase = 3;
                default: if (fetch_done) m_phase = 0;
            endcase
        end
    end

    // Compare, consume commands, answer fetches
    always @(negedge clk) begin
        logic [NQ-1:0] expg;
        if (rst_n) begin
            cyc++;
            expg = (m_phase == 2) ? (NQ'(1) << m_sel) : '0;
            check(grant == expg, cur_req, grant, expg);
            if (|grant) begin
                for (int i = 0; i < NQ; i++) begin
                    if (grant[i]) begin
                        if (depth[i] > 0) depth[i]--;
                        gq.push_back(i);
                    end
                end
                pending = 1'b1;
                dly = resp_delay;
                fetch_done <= 1'b0;
            end else if (pending) begin
                dly--;
                if (dly <= 0) begin
                    fetch_done <= 1'b1;
                    pending = 1'b0;
                end else begin
                    fetch_done <= 1'b0;
                end
            end else begin
                fetch_done <= stray_en && ($urandom % 5 == 0);
            end
        end else begin
            fetch_done <= 1'b0;
        end
    end

    task automatic set_q(input int i, input int d, input logic [1:0] cl);
        depth[i] = d;
        q_prio[2*i +: 2] = cl;
    endtask

    task automatic drain(input int limit);
        int n = 0;
        while ((sum_depth() != 0 || pending) && n < limit) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        #1;
        if (n >= limit) check(1'b0, {cur_req, " watchdog"}, n, limit);
    endtask

    task automatic check_seq(input string req, input int expv[]);
        check(gq.size() == expv.size(), req, gq.size(), expv.size());
        for (int k = 0; k < expv.size() && k < gq.size(); k++)
            check(gq[k] == expv[k], req, gq[k], expv[k]);
    endtask

    initial begin
        for (int i = 0; i < NQ; i++) depth[i] = 0;
        repeat (3) @(negedge clk);
        check(grant == '0, "R1", grant, 0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(grant == '0, "R1", grant, 0);
        #1;

        // R4 plain round robin, class ignored (R5: queue 1 marked urgent)
        cur_req = "R4";
        gq.delete();
        set_q(1, 2, 2'd0); set_q(3, 1, 2'd3); set_q(6, 2, 2'd1);
        drain(400);
        check_seq("R4", '{1, 3, 6, 1, 6});

        // R9 / R10 / R7: high weight 2, low weight 0, burst code 1
        cur_req = "R9";
        wrr_mode = 1'b1;
        arb_cfg = {8'd2, 8'd0, 8'd0, 5'b10101, 3'd1};
        gq.delete();
        set_q(0, 4, 2'd1); set_q(1, 2, 2'd1); set_q(2, 2, 2'd3);
        drain(400);
        check_seq("R10", '{0, 0, 1, 2, 0, 0, 1, 2});

        // R6 urgent strict priority, round robin among urgent
        cur_req = "R6";
        gq.delete();
        set_q(4, 2, 2'd0); set_q(5, 1, 2'd0); set_q(0, 2, 2'd1);
        drain(400);
        check_seq("R6", '{4, 5, 4, 0, 0});

        // R8 unlimited burst, R13 new word only after reload, R12 early empty
        cur_req = "R13";
        arb_cfg = {8'd3, 8'd0, 8'd0, 5'd0, 3'd7};
        gq.delete();
        set_q(0, 6, 2'd1); set_q(1, 6, 2'd1);
        drain(600);
        check_seq("R8", '{1, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 1});

        // R3 long fetch latency with stray pulses
        cur_req = "R3";
        stray_en = 1'b1;
        resp_delay = 20;
        set_q(3, 3, 2'd2); set_q(7, 2, 2'd0);
        drain(800);

        // Mixed random traffic: R11, R12, R5, R7, R2 checked against the model
        for (int b = 0; b < 40; b++) begin
            case (b % 5)
                0: cur_req = "R11";
                1: cur_req = "R12";
                2: cur_req = "R5";
                3: cur_req = "R7";
                default: cur_req = "R2";
            endcase
            wrr_mode = ($urandom % 4) != 0;
            arb_cfg = $urandom;
            resp_delay = 1 + ($urandom % 4);
            for (int i = 0; i < NQ; i++) set_q(i, $urandom % 5, 2'($urandom));
            drain(3000);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        check(1'b0, "watchdog", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule